// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a memory-mapped slave that serves a 32 MB alias window. Each 32-bit slot in the window stands for exactly one bit of an underlying byte-addressed memory, which the bridge reaches through its own master port. A read of a slot returns that single bit as 0 or 1. A write of a slot changes only that bit. The bridge does this by reading the whole target unit, changing the one bit and writing the unit back, and it holds the slave handshake until the write-back is complete.

Accesses may be byte, halfword or word sized. The size picks the width of the target unit and how many offset bits form the bit index. The base address of the target region is a parameter. A typical system uses two copies: one with its base at 0x2000_0000, decoded at alias 0x2200_0000, and one with its base at 0x4000_0000, decoded at alias 0x4200_0000. The slave address is the offset within the window. Only its low 25 bits are decoded.

Size codes on both ports are: 0 for byte, 1 for halfword, 2 for word. Code 3 is invalid.

Top module: `bitband_bridge`

## Requirements
- R1: The master address is BASE_ADDR ORed with (slave offset bits [24:0] shifted right by 5). It is then forced to halfword alignment for size 1 and to word alignment for size 2. The master size equals the slave size.
- R2: The bit index inside the target unit depends on the size. Size 0 uses offset bits [4:2]. Size 1 uses offset bits [5:2]. Size 2 uses offset bits [6:2].
- R3: A read makes exactly one master read and no master write. sRdata bit 0 returns the selected bit, and sRdata bits [31:1] are zero.
- R4: A write makes one master read followed by one master write. The write goes to the same address and size as the read. The written unit equals the read unit with only the selected bit replaced by sWdata bit 0.
- R5: Master data is little-endian and right-aligned. A byte uses lanes [7:0] and a halfword uses lanes [15:0], with the lowest-addressed byte in [7:0]. Bit index n is therefore bit n%8 of byte address+n/8.
- R6: sReady is a single-cycle pulse. It is raised only after every master transaction of the access has completed, and at most one master transaction is outstanding at any time.
- R7: A request with size 3 ends with sErr=1 and sRdata=0. It causes no master transaction.
- R8: If mErr is reported on the read, the write-back is skipped and the access ends with sErr=1. If mErr is reported on the write-back, the access also ends with sErr=1. A clean access ends with sErr=0.
- R9: After reset, mReq and sReady are low.
- R10: While mReq is high and mGnt is low, mReq stays high and mAddr, mWrite and mSize hold steady. A new slave request is taken only when the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sReq | input | 1 | Slave request. Held high until sReady is seen |
| sWrite | input | 1 | 1 for write, 0 for read |
| sSize | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| sAddr | input | ADDR_W | Offset within the alias window |
| sWdata | input | 32 | Write data. Only bit 0 is used |
| sReady | output | 1 | One-cycle completion pulse |
| sRdata | output | 32 | Selected bit in bit 0 |
| sErr | output | 1 | Error flag, valid with sReady |
| mReq | output | 1 | Master request, held until mGnt |
| mWrite | output | 1 | Master direction |
| mSize | output | 2 | Master unit size code |
| mAddr | output | ADDR_W | Master byte address |
| mWdata | output | 32 | Master write data, right-aligned |
| mGnt | input | 1 | Master request accepted |
| mDone | input | 1 | Master transaction finished |
| mRdata | input | 32 | Master read data, right-aligned, valid with mDone |
| mErr | input | 1 | Master error, valid with mDone |

## Verification
The assertions check the following on every cycle:
- sReady is a single pulse and never arrives while a master transaction is outstanding.
- A held master request keeps its address and direction.
- Master addresses are aligned to their size.
- Each write-back targets the address of the read before it.
- sRdata carries nothing above bit 0.

Only the bench's scenarios can show that the right bit of the right byte is chosen and that neighbouring bits survive a write. The bench sweeps every slot of the first 16 target bytes at all three sizes and compares against a shadow memory. The same applies to how invalid sizes and master errors end an access, and to the count of master transactions per access.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture slave request fields
    logic latchRd;    // capture master read data
  } bbStrobe_t;

  localparam int unsigned UNIT_W  = 32;
  localparam int unsigned IDX_W   = 5;

endpackage

// File: rtl/bitband_dpath.sv
module bitband_dpath
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_LOG2  = 25,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strobe,
  input  logic              sWrite,
  input  logic [1:0]        sSize,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic [UNIT_W-1:0] sWdata,
  input  logic [UNIT_W-1:0] mRdata,
  output logic              reqBad,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [UNIT_W-1:0] mWdata,
  output logic [UNIT_W-1:0] sRdata
);

  localparam int unsigned SLOT_SHIFT = 5;
  localparam int unsigned PAD_W      = ADDR_W - WIN_LOG2;

  logic [ADDR_W-1:0] winOff;
  logic [ADDR_W-1:0] rawTgt;
  logic [ADDR_W-1:0] alignTgt;
  logic [IDX_W-1:0]  idxNext;
  accSize_e          sizeIn;

  logic [ADDR_W-1:0] tgtQ;
  logic [IDX_W-1:0]  idxQ;
  accSize_e          sizeQ;
  logic              setQ;
  logic              writeQ;
  logic [UNIT_W-1:0] unitQ;
  logic [UNIT_W-1:0] unitMask;
  logic [UNIT_W-1:0] bitMask;

  assign sizeIn = accSize_e'(sSize);
  assign reqBad = (sizeIn == SZ_BAD);

  // alias offset to target byte address
  assign winOff = {{PAD_W{1'b0}}, sAddr[WIN_LOG2-1:0]};
  assign rawTgt = BASE_ADDR | (winOff >> SLOT_SHIFT);

  always_comb begin
    alignTgt = rawTgt;
    idxNext  = '0;
    unique case (sizeIn)
      SZ_HALF: begin
        alignTgt = {rawTgt[ADDR_W-1:1], 1'b0};
        idxNext  = {1'b0, sAddr[5:2]};
      end
      SZ_WORD: begin
        alignTgt = {rawTgt[ADDR_W-1:2], 2'b00};
        idxNext  = sAddr[6:2];
      end
      default: begin
        alignTgt = rawTgt;
        idxNext  = {2'b00, sAddr[4:2]};
      end
    endcase
  end

  // lanes that belong to the latched unit size
  always_comb begin
    unique case (sizeQ)
      SZ_HALF: unitMask = 32'h0000_FFFF;
      SZ_WORD: unitMask = 32'hFFFF_FFFF;
      default: unitMask = 32'h0000_00FF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ   <= '0;
      idxQ   <= '0;
      sizeQ  <= SZ_BYTE;
      setQ   <= 1'b0;
      writeQ <= 1'b0;
    end else if (strobe.latchReq) begin
      tgtQ   <= alignTgt;
      idxQ   <= idxNext;
      sizeQ  <= sizeIn;
      setQ   <= sWdata[0];
      writeQ <= sWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitQ <= '0;
    end else if (strobe.latchReq) begin
      unitQ <= '0;
    end else if (strobe.latchRd) begin
      unitQ <= mRdata & unitMask;
    end
  end

  assign bitMask  = UNIT_W'(1) << idxQ;
  assign reqWrite = writeQ;
  assign mAddr    = tgtQ;
  assign mSize    = sizeQ;
  assign mWdata   = setQ ? (unitQ | bitMask) : (unitQ & ~bitMask);
  assign sRdata   = {{(UNIT_W-1){1'b0}}, |(unitQ & bitMask)};

endmodule

// File: rtl/bitband_ctrl.sv
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sReq,
  input  logic      reqBad,
  input  logic      reqWrite,
  input  logic      mGnt,
  input  logic      mDone,
  input  logic      mErr,
  output bbStrobe_t strobe,
  output logic      mReq,
  output logic      mWrite,
  output logic      sReady,
  output logic      sErr
);

  bbState_e stateQ, stateD;
  logic     errQ, errD;

  always_comb begin
    stateD         = stateQ;
    errD           = errQ;
    strobe         = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (sReq) begin
          strobe.latchReq = 1'b1;
          errD            = reqBad;
          stateD          = reqBad ? ST_RESP : ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (mGnt) stateD = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mDone) begin
          strobe.latchRd = 1'b1;
          if (mErr) begin
            errD   = 1'b1;
            stateD = ST_RESP;
          end else begin
            stateD = reqWrite ? ST_WR_REQ : ST_RESP;
          end
        end
      end
      ST_WR_REQ:  if (mGnt) stateD = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (mDone) begin
          errD   = mErr;
          stateD = ST_RESP;
        end
      end
      ST_RESP:    stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  assign mReq   = (stateQ == ST_RD_REQ) || (stateQ == ST_WR_REQ);
  assign mWrite = (stateQ == ST_WR_REQ);
  assign sReady = (stateQ == ST_RESP);
  assign sErr   = sReady & errQ;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_LOG2  = 25,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sReq,
  input  logic              sWrite,
  input  logic [1:0]        sSize,
  input  logic [ADDR_W-1:0] sAddr,
  input  logic [31:0]       sWdata,
  output logic              sReady,
  output logic [31:0]       sRdata,
  output logic              sErr,
  output logic              mReq,
  output logic              mWrite,
  output logic [1:0]        mSize,
  output logic [ADDR_W-1:0] mAddr,
  output logic [31:0]       mWdata,
  input  logic              mGnt,
  input  logic              mDone,
  input  logic [31:0]       mRdata,
  input  logic              mErr
);

  bbStrobe_t strobe;
  logic      reqBad;
  logic      reqWrite;
  logic [31:0] bitData;

  bitband_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sReq     (sReq),
    .reqBad   (reqBad),
    .reqWrite (reqWrite),
    .mGnt     (mGnt),
    .mDone    (mDone),
    .mErr     (mErr),
    .strobe   (strobe),
    .mReq     (mReq),
    .mWrite   (mWrite),
    .sReady   (sReady),
    .sErr     (sErr)
  );

  bitband_dpath #(
    .ADDR_W    (ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .BASE_ADDR (BASE_ADDR)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sWrite   (sWrite),
    .sSize    (sSize),
    .sAddr    (sAddr),
    .sWdata   (sWdata),
    .mRdata   (mRdata),
    .reqBad   (reqBad),
    .reqWrite (reqWrite),
    .mAddr    (mAddr),
    .mSize    (mSize),
    .mWdata   (mWdata),
    .sRdata   (bitData)
  );

  assign sRdata = sReady ? bitData : '0;

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sReady,
  input logic [31:0]       sRdata,
  input logic              mReq,
  input logic              mWrite,
  input logic [1:0]        mSize,
  input logic [ADDR_W-1:0] mAddr,
  input logic              mGnt,
  input logic              mDone
);

  logic              inFlight;
  logic [ADDR_W-1:0] lastRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight   <= 1'b0;
      lastRdAddr <= '0;
    end else begin
      if (mDone)             inFlight <= 1'b0;
      else if (mReq && mGnt) inFlight <= 1'b1;
      if (mReq && mGnt && !mWrite) lastRdAddr <= mAddr;
    end
  end

  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    sReady |=> !sReady);
  assert_resp_after_master_R6: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> !inFlight);
  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> !inFlight);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mGnt) |=> (mReq && $stable(mAddr) && $stable(mWrite) && $stable(mSize)));
  assert_word_align_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mSize == 2'd2) |-> (mAddr[1:0] == 2'b00));
  assert_half_align_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mSize == 2'd1) |-> (mAddr[0] == 1'b0));
  assert_writeback_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mWrite) |-> (mAddr == lastRdAddr));
  assert_rdata_single_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    sRdata[31:1] == 31'd0);

endmodule

bind bitband_bridge bitband_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sReady (sReady),
  .sRdata (sRdata),
  .mReq   (mReq),
  .mWrite (mWrite),
  .mSize  (mSize),
  .mAddr  (mAddr),
  .mGnt   (mGnt),
  .mDone  (mDone)
);

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int MEM_BYTES = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sReq = 1'b0;
  logic        sWrite = 1'b0;
  logic [1:0]  sSize = 2'd0;
  logic [31:0] sAddr = '0;
  logic [31:0] sWdata = '0;
  logic        sReady;
  logic [31:0] sRdata;
  logic        sErr;
  logic        mReq;
  logic        mWrite;
  logic [1:0]  mSize;
  logic [31:0] mAddr;
  logic [31:0] mWdata;
  logic        mGnt = 1'b0;
  logic        mDone = 1'b0;
  logic [31:0] mRdata = '0;
  logic        mErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge dut_i (
    .clk(clk), .rstN(rstN),
    .sReq(sReq), .sWrite(sWrite), .sSize(sSize), .sAddr(sAddr), .sWdata(sWdata),
    .sReady(sReady), .sRdata(sRdata), .sErr(sErr),
    .mReq(mReq), .mWrite(mWrite), .mSize(mSize), .mAddr(mAddr), .mWdata(mWdata),
    .mGnt(mGnt), .mDone(mDone), .mRdata(mRdata), .mErr(mErr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // memory model and shadow
  logic [7:0] mem    [MEM_BYTES];
  logic [7:0] shadow [MEM_BYTES];

  int          nRd, nWr, txn, gntWait, doneWait;
  logic        busy;
  logic        curWrite;
  logic [1:0]  curSize;
  logic [31:0] curAddr, curWdata;
  logic        errOnRead, errOnWrite;
  logic [31:0] expAddr;
  logic [1:0]  expSize;

  always @(negedge clk) begin
    mGnt = 1'b0; mDone = 1'b0; mErr = 1'b0;
    if (!rstN) begin
      busy = 1'b0; gntWait = 0; doneWait = 0; txn = 0;
    end else if (busy) begin
      if (doneWait == 0) begin
        int a;
        mDone = 1'b1;
        busy  = 1'b0;
        a = int'(curAddr[7:0]);
        if (!curWrite) begin
          mErr   = errOnRead;
          mRdata = {mem[(a+3)%MEM_BYTES], mem[(a+2)%MEM_BYTES], mem[(a+1)%MEM_BYTES], mem[a]};
          if (curSize == 2'd0) mRdata[31:8] = 24'hA5A5A5;   // junk upper lanes
          if (curSize == 2'd1) mRdata[31:16] = 16'h5A5A;
        end else begin
          mErr = errOnWrite;
          if (!errOnWrite) begin
            mem[a] = curWdata[7:0];
            if (curSize != 2'd0) mem[(a+1)%MEM_BYTES] = curWdata[15:8];
            if (curSize == 2'd2) begin
              mem[(a+2)%MEM_BYTES] = curWdata[23:16];
              mem[(a+3)%MEM_BYTES] = curWdata[31:24];
            end
          end
        end
      end else doneWait--;
    end else if (mReq) begin
      if (gntWait == 0) begin
        mGnt = 1'b1; busy = 1'b1;
        curWrite = mWrite; curSize = mSize; curAddr = mAddr; curWdata = mWdata;
        if (mWrite) nWr++; else nRd++;
        check(mAddr == expAddr, "R1 master address", mAddr, expAddr);
        check(mSize == expSize, "R1 master size", {30'd0, mSize}, {30'd0, expSize});
        doneWait = txn % 3;
        txn++;
        gntWait = txn % 2;
      end else gntWait--;
    end
  end

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] off,
                        input logic wbit, output logic [31:0] rd, output logic err);
    @(negedge clk);
    sReq = 1'b1; sWrite = wr; sSize = sz; sAddr = off; sWdata = {31'h7FFF_FFFE, wbit};
    forever begin
      @(negedge clk);
      if (sReady) break;
    end
    rd = sRdata; err = sErr;
    sReq = 1'b0;
  endtask

  function automatic logic [31:0] tgtOf(input logic [1:0] sz, input logic [31:0] off);
    logic [31:0] t;
    t = BASE | ({7'd0, off[24:0]} >> 5);
    if (sz == 2'd1) t[0] = 1'b0;
    if (sz == 2'd2) t[1:0] = 2'b00;
    return t;
  endfunction

  function automatic int idxOf(input logic [1:0] sz, input logic [31:0] off);
    if (sz == 2'd0) return int'(off[4:2]);
    if (sz == 2'd1) return int'(off[5:2]);
    return int'(off[6:2]);
  endfunction

  bit memOk;

  initial begin
    logic [31:0] rd;
    logic        err;
    errOnRead = 1'b0; errOnWrite = 1'b0;
    nRd = 0; nWr = 0;
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i] = 8'((i * 37 + 5) ^ (i >> 1));
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(mReq == 1'b0, "R9 mReq after reset", {31'd0, mReq}, 32'd0);
    check(sReady == 1'b0, "R9 sReady after reset", {31'd0, sReady}, 32'd0);
    rstN = 1'b1;

    // sweep: every slot of the first 16 bytes at each size
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 512; off += 4) begin
        int t, b, byteA, bitB;
        logic exp, nv;
        t = int'(tgtOf(2'(sz), 32'(off)) & 32'hFF);
        b = idxOf(2'(sz), 32'(off));
        byteA = t + b / 8; bitB = b % 8;
        exp = shadow[byteA][bitB];
        expAddr = tgtOf(2'(sz), 32'(off)); expSize = 2'(sz);
        nRd = 0; nWr = 0;
        access(1'b0, 2'(sz), 32'(off) | 32'h0200_0000, 1'b0, rd, err);
        check(rd == {31'd0, exp}, "R2 R5 read bit value", rd, {31'd0, exp});
        check(nRd == 1 && nWr == 0, "R3 read master count", 32'(nRd * 16 + nWr), 32'd16);
        check(err == 1'b0, "R8 clean read sErr", {31'd0, err}, 32'd0);
        nv = ~exp;
        nRd = 0; nWr = 0;
        access(1'b1, 2'(sz), 32'(off), nv, rd, err);
        shadow[byteA][bitB] = nv;
        check(nRd == 1 && nWr == 1, "R4 write master count", 32'(nRd * 16 + nWr), 32'd17);
        check(err == 1'b0, "R8 clean write sErr", {31'd0, err}, 32'd0);
        memOk = 1'b1;
        for (int i = 0; i < 32; i++) if (mem[i] !== shadow[i]) memOk = 1'b0;
        check(memOk, "R4 R5 only selected bit changed", {31'd0, memOk}, 32'd1);
      end
    end

    // invalid size
    nRd = 0; nWr = 0;
    access(1'b1, 2'd3, 32'h40, 1'b1, rd, err);
    check(err == 1'b1, "R7 invalid size sErr", {31'd0, err}, 32'd1);
    check(nRd + nWr == 0, "R7 no master access", 32'(nRd + nWr), 32'd0);
    check(rd == 32'd0, "R7 rdata zero", rd, 32'd0);

    // error on read skips write-back
    errOnRead = 1'b1; nRd = 0; nWr = 0;
    expAddr = tgtOf(2'd2, 32'h8); expSize = 2'd2;
    access(1'b1, 2'd2, 32'h8, 1'b1, rd, err);
    check(err == 1'b1, "R8 read error sErr", {31'd0, err}, 32'd1);
    check(nWr == 0, "R8 write-back skipped", 32'(nWr), 32'd0);
    errOnRead = 1'b0;

    // error on write-back
    errOnWrite = 1'b1; nRd = 0; nWr = 0;
    expAddr = tgtOf(2'd1, 32'h24); expSize = 2'd1;
    access(1'b1, 2'd1, 32'h24, 1'b0, rd, err);
    check(err == 1'b1, "R8 write error sErr", {31'd0, err}, 32'd1);
    check(nRd == 1 && nWr == 1, "R8 write error counts", 32'(nRd * 16 + nWr), 32'd17);
    errOnWrite = 1'b0;

    // R10: request held while grant delayed is covered by the responder wait states
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule